// File: doc/BRIEF.md
# Serial Configuration Loader and Start-Up Sequencer

This block takes a receiver core from power-on reset to normal operation. An active-low reset pin is passed through a three-stage flip-flop chain. The synchronized copy then resets every internal register synchronously. When reset is released, the block asks a host controller for configuration data one bit at a time over a four-phase request/acknowledge exchange on a single data wire. The payload has a variable length. It starts with a two-bit length selector, then carries the spreading-code chips, and ends with a fixed block of parameter bits.

Code chips go out as single-bit writes with an address, for storage in the code column of the input-sample memory. Parameter bits are shifted into a parallel configuration word. Once the last bit is in, the block runs one clearing pass over the memories. Each cycle it issues a zero-write strobe with an address, for the coefficient memory and for the data columns of the input memory. The code column is left untouched during this pass. After the pass the block raises a steady operating flag and emits a one-cycle completion pulse, which let the enable sequencer downstream start.

Top module: `cfg_init_ctrl`

## Requirements
- R1: While the synchronized reset is low, and from the fourth clock after `rst_n` is sampled low, `req`, `code_we`, `clr_we`, `op_active` and `init_done` are 0 and `cfg_word` is all zeros, whatever state the block was in.
- R2: `req` rises while waiting for a bit. It falls within a few cycles of `ack` going high. It stays low for as long as `ack` stays high, and it rises for the next bit only after `ack` has gone low.
- R3: The first received bit is the low bit of the length selector and the second is the high bit. Selector 0 gives L = LBASE, 1 gives L = 2·LBASE, and 2 or 3 give L = 4·LBASE (32, 64 and 128 with defaults).
- R4: Received bits 2 to L+1 are code chips. Each produces exactly one `code_we` pulse, with `code_addr` equal to the chip index (0 for the first chip) and `code_bit` equal to the received value. There are exactly L pulses per load.
- R5: The last CFG_W (55) bits are shifted into `cfg_word` so that, at the end, `cfg_word[k]` equals received bit L+2+k.
- R6: Receiving has no timeout. If the host never answers, `req` stays high and neither memory strobe fires, however long the wait.
- R7: After the final bit, `clr_we` is high for exactly 3L consecutive cycles, with `clr_addr` stepping 0, 1, …, 3L−1. No `code_we` pulse occurs during this pass.
- R8: `op_active` rises in the cycle after the last clear write, together with a single-cycle `init_done` pulse, and stays high until reset.
- R9: A reset applied in the middle of a load, or after operation has begun, restarts the sequence, and a following complete load succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous to the block |
| ack | input | 1 | Host acknowledge: data bit is valid |
| txd | input | 1 | Serial configuration data bit |
| req | output | 1 | Request for the next bit |
| code_we | output | 1 | Code-chip write strobe |
| code_addr | output | $clog2(4*LBASE) | Code-chip index |
| code_bit | output | 1 | Code-chip value |
| cfg_word | output | CFG_W | Parallel configuration parameters |
| clr_we | output | 1 | Zero-write strobe for the memory clearing pass |
| clr_addr | output | $clog2(12*LBASE) | Word address being cleared |
| op_active | output | 1 | Normal operation enabled |
| init_done | output | 1 | One-cycle pulse on entering operation |

## Verification
The bench covers every length selector, including the redundant value 2. A decoder that treated that value as its own case would write the wrong number of chips and misplace the parameter bits. It holds `ack` high after `req` drops and stalls the host for a long time. This exposes a handshake that re-requests early or a receiver that gives up on a timeout. It counts and orders the clearing writes and checks where `op_active` rises relative to them, which exposes an off-by-one sweep or an early start. It also checks that no code write appears during the clear. Resets in mid-load and in operation confirm that the bit counter and the length selector restart cleanly.

// File: rtl/cfg_init_ctrl.sv
module cfg_init_ctrl #(
  parameter int LBASE = 32,
  parameter int CFG_W = 55,
  localparam int LMAX    = 4 * LBASE,
  localparam int CODE_AW = $clog2(LMAX),
  localparam int CLR_AW  = $clog2(3 * LMAX),
  localparam int CNT_W   = $clog2(LMAX + CFG_W + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack,
  input  logic               txd,
  output logic               req,
  output logic               code_we,
  output logic [CODE_AW-1:0] code_addr,
  output logic               code_bit,
  output logic [CFG_W-1:0]   cfg_word,
  output logic               clr_we,
  output logic [CLR_AW-1:0]  clr_addr,
  output logic               op_active,
  output logic               init_done
);

  typedef enum logic [1:0] {S_RST, S_REC, S_ERASE, S_OP} st_t;

  st_t              st;
  logic [2:0]       rsync;
  logic             srst_n;
  logic             ack_q, dat_q;
  logic [1:0]       lcode;
  logic [CNT_W-1:0] bcnt, llen, nbits;
  logic [CLR_AW-1:0] erase_last;
  logic             take;

  always_ff @(posedge clk) rsync <= {rsync[1:0], rst_n};
  assign srst_n = rsync[2];

  always_comb begin
    case (lcode)
      2'd0:    llen = CNT_W'(LBASE);
      2'd1:    llen = CNT_W'(2 * LBASE);
      default: llen = CNT_W'(4 * LBASE);
    endcase
  end

  assign nbits      = llen + CNT_W'(CFG_W + 2);
  assign erase_last = CLR_AW'(llen) * CLR_AW'(3) - CLR_AW'(1);
  assign take       = (st == S_REC) && req && ack_q;

  always_ff @(posedge clk) begin
    if (!srst_n) begin
      st        <= S_RST;
      ack_q     <= 1'b0;
      dat_q     <= 1'b0;
      req       <= 1'b0;
      bcnt      <= '0;
      lcode     <= '0;
      code_we   <= 1'b0;
      code_addr <= '0;
      code_bit  <= 1'b0;
      cfg_word  <= '0;
      clr_we    <= 1'b0;
      clr_addr  <= '0;
      op_active <= 1'b0;
      init_done <= 1'b0;
    end else begin
      ack_q     <= ack;
      dat_q     <= txd;
      code_we   <= 1'b0;
      init_done <= 1'b0;
      case (st)
        S_RST: begin
          st  <= S_REC;
          req <= 1'b1;
        end
        S_REC: begin
          if (take) begin
            req  <= 1'b0;
            bcnt <= bcnt + CNT_W'(1);
            if (bcnt < CNT_W'(2))
              lcode[bcnt[0]] <= dat_q;
            else if (bcnt < llen + CNT_W'(2)) begin
              code_we   <= 1'b1;
              code_addr <= CODE_AW'(bcnt - CNT_W'(2));
              code_bit  <= dat_q;
            end else
              cfg_word <= {dat_q, cfg_word[CFG_W-1:1]};
            if (bcnt == nbits - CNT_W'(1)) begin
              st       <= S_ERASE;
              clr_we   <= 1'b1;
              clr_addr <= '0;
            end
          end else if (!req && !ack_q) begin
            req <= 1'b1;
          end
        end
        S_ERASE: begin
          if (clr_addr == erase_last) begin
            clr_we    <= 1'b0;
            st        <= S_OP;
            op_active <= 1'b1;
            init_done <= 1'b1;
          end else begin
            clr_addr <= clr_addr + CLR_AW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (st == S_RST) |-> (!req && !code_we && !clr_we && !op_active));

  p_req_drop_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (st == S_REC && req && ack_q) |=> !req);

  p_req_wait_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (!req && ack_q) |=> !req);

  p_no_code_in_clear_r7: assert property (@(posedge clk) disable iff (!srst_n)
    clr_we |-> !code_we);

  p_clr_step_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_we && $past(clr_we)) |-> (clr_addr == $past(clr_addr) + CLR_AW'(1)));

  p_done_with_op_r8: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(op_active) |-> (init_done && !clr_we));

  p_op_sticky_r8: assert property (@(posedge clk) disable iff (!srst_n)
    op_active |=> op_active);

endmodule

// File: tb/cfg_init_ctrl_test.sv
module cfg_init_ctrl_test;
  logic clk = 0, rst_n = 0, ack = 0, txd = 0;
  logic req, code_we, code_bit, clr_we, op_active, init_done;
  logic [6:0] code_addr;
  logic [54:0] cfg_word;
  logic [8:0] clr_addr;

  int n_run = 0, n_fail = 0;
  int n_code, n_clr, clr_bad, n_done, clr_at_done, code_in_clr;
  logic cap [0:127];

  always #5 clk = ~clk;

  cfg_init_ctrl uut (.clk, .rst_n, .ack, .txd, .req, .code_we, .code_addr,
    .code_bit, .cfg_word, .clr_we, .clr_addr, .op_active, .init_done);

  always @(negedge clk) begin
    if (code_we) begin
      cap[code_addr] = code_bit;
      n_code++;
      if (n_clr > 0) code_in_clr++;
    end
    if (clr_we) begin
      if (int'(clr_addr) != n_clr) clr_bad++;
      n_clr++;
    end
    if (init_done) begin
      n_done++;
      clr_at_done = n_clr;
    end
  end

  task automatic chk(input bit ok, input string req_id, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_id, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_code = 0; n_clr = 0; clr_bad = 0; n_done = 0; clr_at_done = -1; code_in_clr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; ack = 0; txd = 0;
    repeat (8) @(negedge clk);
    clr_mon();
    rst_n = 1;
  endtask

  function automatic bit cbit(int i, int seed);
    return ((i * 7 + seed) % 5) < 2;
  endfunction

  task automatic send_bit(input bit b, inout int hs_err);
    int w = 0;
    while (!req && w < 2000) begin @(negedge clk); w++; end
    if (!req) hs_err++;
    txd = b; ack = 1;
    w = 0;
    while (req && w < 20) begin @(negedge clk); w++; end
    if (req) hs_err++;
    repeat (3) begin @(negedge clk); if (req) hs_err++; end
    ack = 0;
    @(negedge clk);
  endtask

  task automatic t_load(input bit [1:0] lc, input int exp_l, input int seed);
    int hs_err = 0, bad = 0, w = 0;
    logic [54:0] cfg = 55'h5AC3F01E2D3B4C ^ 55'(seed * 1237);
    do_reset();
    send_bit(lc[0], hs_err);
    send_bit(lc[1], hs_err);
    for (int i = 0; i < exp_l; i++) send_bit(cbit(i, seed), hs_err);
    for (int k = 0; k < 55; k++) send_bit(cfg[k], hs_err);
    while (!op_active && w < 2000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    chk(hs_err == 0, "R2 handshake errors", hs_err, 0);
    chk(n_code == exp_l, "R3 R4 code write count", n_code, exp_l);
    for (int i = 0; i < exp_l; i++) if (cap[i] !== cbit(i, seed)) bad++;
    chk(bad == 0, "R4 code chip mismatches", bad, 0);
    chk(cfg_word == cfg, "R5 cfg word", cfg_word, cfg);
    chk(n_clr == 3 * exp_l, "R7 clear count", n_clr, 3 * exp_l);
    chk(clr_bad == 0 && code_in_clr == 0, "R7 clear order/code", clr_bad + code_in_clr, 0);
    chk(op_active === 1'b1, "R8 op active", op_active, 1);
    chk(n_done == 1 && clr_at_done == 3 * exp_l, "R8 done after clear", clr_at_done, 3 * exp_l);
  endtask

  task automatic t_stall();
    int bad = 0, hs_err = 0;
    do_reset();
    send_bit(1'b0, hs_err);
    repeat (500) begin
      @(negedge clk);
      if (!req || clr_we || code_we || op_active) bad++;
    end
    chk(bad == 0 && hs_err == 0, "R6 stall without timeout", bad, 0);
  endtask

  task automatic t_reset_check(input string tag);
    rst_n = 0; ack = 0;
    repeat (6) @(negedge clk);
    chk({req, code_we, clr_we, op_active, init_done} == 5'b0 && cfg_word == '0,
        tag, {req, code_we, clr_we, op_active, init_done}, 0);
  endtask

  task automatic t_midreset();
    int hs_err = 0;
    do_reset();
    for (int i = 0; i < 12; i++) send_bit(i[0], hs_err);
    t_reset_check("R1 R9 reset mid-load");
    t_load(2'b00, 32, 3);
    t_reset_check("R1 R9 reset in operation");
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_check("R1 initial reset");
    t_load(2'b00, 32, 1);
    t_load(2'b01, 64, 2);
    t_load(2'b11, 128, 4);
    t_load(2'b10, 128, 5);
    t_stall();
    t_midreset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule